// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls a small bank of general-purpose pins through three registers on a single-cycle register bus. The registers are an output latch, a per-pin direction mask and a per-pin pull-up request mask. The block sends each pin's drive value, drive enable and pull-up control to the pad ring. It also takes each pad's input level through a two-stage synchronizer.

A read of the data offset returns a mix of two sources, chosen per bit by the direction mask. Pins set as outputs return their latched value. Pins set as inputs return their synchronized pad level. A pull-up is requested only for a pin that is an input and has its pull-up bit set. An input pin without that bit floats. Software can load the latch first and then turn on the driver, so the pin is never driven with a stale value.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the latch, direction and pull-up registers all hold 0. pad_oe, pad_out and pad_pu_en are all 0, and every pin is an input.
- R2: Offset 0x4 holds the direction mask in bits 6:0, where 1 means output and 0 means input. pad_oe shows a written mask from the clock edge that takes the write. A read returns the mask with bit 7 at 0.
- R3: A read of offset 0x0 returns, for each of bits 6:0, the synchronized pad level when that pin's direction bit is 0. Bit 7 always reads 0.
- R4: A write to offset 0x0 updates the latch (bits 6:0) whatever the direction bits hold. pad_out shows it after the edge, and a read returns it for every pin whose direction bit is 1.
- R5: pad_pu_en[i] is 1 only when pull-up bit i is 1 and direction bit i is 0.
- R6: An input pin whose pull-up bit is 0 has both pad_oe and pad_pu_en at 0 (high impedance).
- R7: If the latch is written before a pin's direction bit goes from 0 to 1, then in the first cycle pad_oe is 1, pad_out already carries the latched value.
- R8: Offset 0x8 holds the pull-up mask in bits 6:0. It is readable and writable, and bit 7 reads 0.
- R9: A pad level change shows in a data read only after two rising clock edges.
- R10: A read of any offset other than 0x0, 0x4 or 0x8 returns 0. A write to such an offset changes no register and no pad output.
- R11: A read in the same cycle as a write to the same offset returns the contents from before the write. The new value appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read (with bus_sel) |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, 0 when idle) |
| pad_in | input | 7 | Raw pad input levels |
| pad_out | output | 7 | Per-pin drive value |
| pad_oe | output | 7 | Per-pin drive enable |
| pad_pu_en | output | 7 | Per-pin pull-up enable |

## Verification
Two things can land in the same cycle: a register update and the combinational read-back of that register. The bench drives a data write and a read of offset 0x0 together in one cycle. It expects the old latch value in that cycle and the new one in the next. In the same way it raises a direction bit whose latch was loaded earlier, then checks pad_oe and pad_out together in the first cycle after the edge. A pad change that arrives while a read is held is judged cycle by cycle. The read must show the old level for two edges and then the new one.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic [1:0] {
      RSEL_NONE = 2'd0,
      RSEL_DATA = 2'd1,
      RSEL_DIR  = 2'd2,
      RSEL_PUE  = 2'd3
   } rsel_e;

   function automatic rsel_e decode_offset(input logic [7:0] addr,
                                           input logic [7:0] off_data,
                                           input logic [7:0] off_dir,
                                           input logic [7:0] off_pue);
      if (addr == off_data)     return RSEL_DATA;
      else if (addr == off_dir) return RSEL_DIR;
      else if (addr == off_pue) return RSEL_PUE;
      else                      return RSEL_NONE;
   endfunction
endpackage

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
   import gpio_pkg::*;
#(
   parameter int NUM_PINS = 7,
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8,
   parameter int OFF_DATA = 0,
   parameter int OFF_DIR  = 4,
   parameter int OFF_PUE  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output rsel_e               rd_sel,
   output logic [NUM_PINS-1:0] latch_q,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] pue_q
);
   localparam logic [7:0] OD = 8'(OFF_DATA);
   localparam logic [7:0] OR = 8'(OFF_DIR);
   localparam logic [7:0] OP = 8'(OFF_PUE);

   rsel_e               hit;
   logic [NUM_PINS-1:0] wfield;
   logic                wr;

   assign hit    = decode_offset(8'(bus_addr), OD, OR, OP);
   assign rd_sel = bus_sel ? hit : RSEL_NONE;
   assign wr     = bus_sel & bus_we;
   assign wfield = bus_wdata[NUM_PINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
         pue_q   <= '0;
      end else if (wr) begin
         case (hit)
            RSEL_DATA: latch_q <= wfield;
            RSEL_DIR:  dir_q   <= wfield;
            RSEL_PUE:  pue_q   <= wfield;
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int NUM_PINS = 7,
   parameter int STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] raw,
   output logic [NUM_PINS-1:0] synced
);
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], raw[p]};
      end
      assign synced[p] = chain[STAGES-1];
   end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
   import gpio_pkg::*;
#(
   parameter int NUM_PINS = 7,
   parameter int DATA_W   = 8
) (
   input  rsel_e               rd_sel,
   input  logic [NUM_PINS-1:0] latch_q,
   input  logic [NUM_PINS-1:0] dir_q,
   input  logic [NUM_PINS-1:0] pue_q,
   input  logic [NUM_PINS-1:0] pin_sync,
   output logic [DATA_W-1:0]   rdata
);
   localparam int PAD_W = DATA_W - NUM_PINS;

   logic [NUM_PINS-1:0] data_view;
   logic [NUM_PINS-1:0] field;

   for (genvar b = 0; b < NUM_PINS; b++) begin : g_bit
      assign data_view[b] = dir_q[b] ? latch_q[b] : pin_sync[b];
   end

   always_comb begin
      case (rd_sel)
         RSEL_DATA: field = data_view;
         RSEL_DIR:  field = dir_q;
         RSEL_PUE:  field = pue_q;
         default:   field = '0;
      endcase
   end

   assign rdata = {{PAD_W{1'b0}}, field};
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
   parameter int NUM_PINS = 7
) (
   input  logic [NUM_PINS-1:0] latch_q,
   input  logic [NUM_PINS-1:0] dir_q,
   input  logic [NUM_PINS-1:0] pue_q,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_pu_en
);
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign pad_out[p]   = latch_q[p];
      assign pad_oe[p]    = dir_q[p];
      assign pad_pu_en[p] = pue_q[p] & ~dir_q[p];
   end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_pkg::*;
#(
   parameter int NUM_PINS    = 7,
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int OFF_DATA    = 0,
   parameter int OFF_DIR     = 4,
   parameter int OFF_PUE     = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_pu_en
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (NUM_PINS < 1 || NUM_PINS >= DATA_W) begin : g_bad_width
      $error("gpio_port_ctrl: NUM_PINS must be between 1 and DATA_W-1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_port_ctrl: SYNC_STAGES must be at least 2");
   end
   if (ADDR_W > 8 || OFF_DATA >= ADDR_SPAN || OFF_DIR >= ADDR_SPAN || OFF_PUE >= ADDR_SPAN) begin : g_bad_off
      $error("gpio_port_ctrl: register offsets do not fit the address width");
   end
   if (OFF_DATA == OFF_DIR || OFF_DATA == OFF_PUE || OFF_DIR == OFF_PUE) begin : g_dup_off
      $error("gpio_port_ctrl: register offsets must be distinct");
   end

   rsel_e               rd_sel;
   logic [NUM_PINS-1:0] latch_q;
   logic [NUM_PINS-1:0] dir_q;
   logic [NUM_PINS-1:0] pue_q;
   logic [NUM_PINS-1:0] pin_sync;

   gpio_reg_file #(
      .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .OFF_DATA(OFF_DATA), .OFF_DIR(OFF_DIR), .OFF_PUE(OFF_PUE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_sel(rd_sel),
      .latch_q(latch_q), .dir_q(dir_q), .pue_q(pue_q)
   );

   gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw(pad_in), .synced(pin_sync)
   );

   gpio_rd_mux #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_rmux (
      .rd_sel(rd_sel), .latch_q(latch_q), .dir_q(dir_q), .pue_q(pue_q),
      .pin_sync(pin_sync), .rdata(bus_rdata)
   );

   gpio_pad_ctl #(.NUM_PINS(NUM_PINS)) u_pads (
      .latch_q(latch_q), .dir_q(dir_q), .pue_q(pue_q),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en)
   );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int NUM_PINS = 7,
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8,
   parameter int OFF_DATA = 0,
   parameter int OFF_DIR  = 4,
   parameter int OFF_PUE  = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_sel,
   input logic                bus_we,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] pad_pu_en
);
   logic unmapped;
   assign unmapped = (int'(bus_addr) != OFF_DATA) && (int'(bus_addr) != OFF_DIR) &&
                     (int'(bus_addr) != OFF_PUE);

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && pad_pu_en == '0));

   assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && int'(bus_addr) == OFF_DIR) |=>
         (pad_oe == $past(bus_wdata[NUM_PINS-1:0])));

   assert_rdata_top_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel |-> (bus_rdata[DATA_W-1:NUM_PINS] == '0));

   assert_latch_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && int'(bus_addr) == OFF_DATA) |=>
         (pad_out == $past(bus_wdata[NUM_PINS-1:0])));

   assert_pu_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_pu_en & pad_oe) == '0));

   assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && unmapped) |-> (bus_rdata == '0));

   assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && unmapped) |=>
         ($stable(pad_out) && $stable(pad_oe) && $stable(pad_pu_en)));
endmodule

bind gpio_port_ctrl gpio_port_chk #(
   .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .OFF_DATA(OFF_DATA), .OFF_DIR(OFF_DIR), .OFF_PUE(OFF_PUE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en)
);

// File: tb/tb_gpio_port_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctrl;
   localparam logic [3:0] A_DATA = 4'h0;
   localparam logic [3:0] A_DIR  = 4'h4;
   localparam logic [3:0] A_PUE  = 4'h8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_we = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [6:0] pad_in = '0;
   logic [6:0] pad_out;
   logic [6:0] pad_oe;
   logic [6:0] pad_pu_en;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gpio_port_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en)
   );

   // vector: [33:30] tag, [29] check, [28] write, [27:24] addr, [23:16] wdata, [15:8] pad, [7:0] expected
   localparam int NV = 16;
   localparam logic [33:0] VEC [0:NV-1] = '{
      {4'd1, 1'b1, 1'b0, 4'h4, 8'h00, 8'h00, 8'h00},
      {4'd4, 1'b0, 1'b1, 4'h0, 8'h5A, 8'h7F, 8'h00},
      {4'd3, 1'b1, 1'b0, 4'h0, 8'h00, 8'h7F, 8'h7F},
      {4'd2, 1'b0, 1'b1, 4'h4, 8'h0F, 8'h70, 8'h00},
      {4'd3, 1'b1, 1'b0, 4'h0, 8'h00, 8'h70, 8'h7A},
      {4'd2, 1'b1, 1'b0, 4'h4, 8'h00, 8'h70, 8'h0F},
      {4'd8, 1'b0, 1'b1, 4'h8, 8'hFF, 8'h70, 8'h00},
      {4'd8, 1'b1, 1'b0, 4'h8, 8'h00, 8'h70, 8'h7F},
      {4'd10, 1'b1, 1'b0, 4'hC, 8'h00, 8'h70, 8'h00},
      {4'd10, 1'b0, 1'b1, 4'hC, 8'hFF, 8'h70, 8'h00},
      {4'd10, 1'b1, 1'b0, 4'h4, 8'h00, 8'h70, 8'h0F},
      {4'd4, 1'b0, 1'b1, 4'h0, 8'hA5, 8'h00, 8'h00},
      {4'd4, 1'b1, 1'b0, 4'h0, 8'h00, 8'h00, 8'h05},
      {4'd4, 1'b0, 1'b1, 4'h4, 8'h7F, 8'h55, 8'h00},
      {4'd4, 1'b1, 1'b0, 4'h0, 8'h00, 8'h55, 8'h25},
      {4'd10, 1'b1, 1'b0, 4'h2, 8'h00, 8'h55, 8'h00}
   };

   function automatic string tag_name(input int t);
      case (t)
         1: return "R1";   2: return "R2";   3: return "R3";
         4: return "R4";   8: return "R8";   10: return "R10";
         default: return "R?";
      endcase
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic settle_pad(input logic [6:0] v);
      @(negedge clk);
      pad_in = v;
      repeat (3) @(posedge clk);
   endtask

   initial begin
      repeat (1000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state at the pads
      check("R1 pad_oe", {1'b0, pad_oe}, 8'h00);
      check("R1 pad_out", {1'b0, pad_out}, 8'h00);
      check("R1 pad_pu_en", {1'b0, pad_pu_en}, 8'h00);

      // vector table
      for (int i = 0; i < NV; i++) begin
         settle_pad(VEC[i][14:8]);
         if (VEC[i][28]) bus_write(VEC[i][27:24], VEC[i][23:16]);
         else begin
            bus_read(VEC[i][27:24], rd);
            if (VEC[i][29]) check(tag_name(int'(VEC[i][33:30])), rd, VEC[i][7:0]);
         end
      end
      check("R10 pad_out after ignored write", {1'b0, pad_out}, 8'h25);

      // R5 / R6: pull-up gating (pue = 7F now)
      check("R5 all outputs no pull-up", {1'b0, pad_pu_en}, 8'h00);
      bus_write(A_DIR, 8'h03);
      check("R5 pull-up on input pins", {1'b0, pad_pu_en}, 8'h7C);
      check("R2 pad_oe mask", {1'b0, pad_oe}, 8'h03);
      bus_write(A_PUE, 8'h00);
      check("R6 inputs float pu", {1'b0, pad_pu_en}, 8'h00);
      check("R6 inputs float oe", {1'b0, pad_oe}, 8'h03);

      // R7: preload before enabling the driver
      bus_write(A_DIR, 8'h00);
      bus_write(A_DATA, 8'h40);
      check("R7 preload latched while input", {1'b0, pad_out}, 8'h40);
      check("R7 driver still off", {1'b0, pad_oe}, 8'h00);
      bus_write(A_DIR, 8'h40);
      check("R7 first driven cycle oe", {1'b0, pad_oe}, 8'h40);
      check("R7 first driven cycle value", {1'b0, pad_out}, 8'h40);

      // R9: two-edge synchronizer latency
      bus_write(A_DIR, 8'h00);
      settle_pad(7'h00);
      @(negedge clk);
      pad_in = 7'h7F; bus_sel = 1'b1; bus_we = 1'b0; bus_addr = A_DATA;
      #2 check("R9 before any edge", bus_rdata, 8'h00);
      @(negedge clk);
      #2 check("R9 after one edge", bus_rdata, 8'h00);
      @(negedge clk);
      #2 check("R9 after two edges", bus_rdata, 8'h7F);
      @(negedge clk);
      bus_sel = 1'b0;

      // R11: read and write of the data offset in one cycle
      bus_write(A_DIR, 8'h7F);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_DATA; bus_wdata = 8'h33;
      #2 check("R11 same-cycle read sees old", bus_rdata, 8'h40);
      @(negedge clk);
      bus_we = 1'b0;
      #2 check("R11 next cycle sees new", bus_rdata, 8'h33);
      @(negedge clk);
      bus_sel = 1'b0;

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule